// File: doc/BRIEF.md
# Pause Quanta Transmit Holdoff Timer

This block holds back the start of new outgoing frames after the receive side has decoded a MAC control pause request. The receive path delivers a one-cycle strobe together with the 16-bit quanta value taken from the request. The block loads that value into a down-counter. While the count is nonzero, the grant to the transmit scheduler stays low. A frame that is already being sent is never cut short, because the block only withholds permission to start another one.

The counter steps down once per slot of 512 bit times. The slot is measured by counting pulses on a bit-time tick input, so at 10 Mb/s one step takes 51.2 µs. A new request that arrives while the counter is running replaces the remaining count and restarts the slot measurement. A request with quanta zero ends the holdoff at once. Requests are honoured only when the full-duplex configuration input is high. The receive direction is not touched by this block at all.

Top module: `pause_holdoff`

## Requirements
- R1: `tx_grant_o` is high exactly when `paused_o` is low and `tx_busy_i` is low. A frame in progress (`tx_busy_i` high) is never interrupted by the block.
- R2: A strobe on `pause_valid_i` with `full_duplex_i` high is accepted at that clock edge. From the next cycle, `paused_o` is high if the quanta value is nonzero.
- R3: After an accepted request with quanta Q, `paused_o` falls in the cycle after the (Q*512)-th `bit_tick_i` pulse counted in the cycles following the acceptance edge.
- R4: An accepted request arriving while paused replaces the remaining count with its own quanta. The remaining time is discarded.
- R5: An accepted request with quanta 0 drops `paused_o` in the next cycle, whatever the remaining count was.
- R6: After a synchronous active-low reset, `paused_o` is low and `tx_grant_o` follows `!tx_busy_i`.
- R7: With `full_duplex_i` low, `pause_valid_i` is ignored and the holdoff state does not change.
- R8: Every accepted request restarts the 512-tick slot from zero, so ticks counted before a reload do not shorten the new holdoff.
- R9: Without `bit_tick_i` pulses, the holdoff does not progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| full_duplex_i | input | 1 | High when the link runs full duplex; requests are honoured only then |
| pause_valid_i | input | 1 | One-cycle strobe for a decoded pause request |
| pause_quanta_i | input | 16 | Quanta value carried by the request |
| bit_tick_i | input | 1 | One pulse per bit time on the line |
| tx_busy_i | input | 1 | High while the transmitter is sending a frame |
| tx_grant_o | output | 1 | Permission for the scheduler to start a new frame |
| paused_o | output | 1 | High while the holdoff count is nonzero |

## Verification
A wrong count or slot value inside the block shows at the ports only as a shifted falling edge of `paused_o` and `tx_grant_o`. An error in the slot measurement moves the release by up to 511 ticks. An error in the count moves it by whole multiples of 512 ticks. So the bench predicts the exact release cycle from the number of ticks it has applied, and compares `paused_o` with that prediction in every cycle. A fault in acceptance, reload or zero-quanta release shows on the cycle directly after the strobe.

// File: rtl/pause_pkg.sv
// Package: shared defaults for the pause holdoff block.
// Assumes: users override these only through module parameters.
package pause_pkg;
    localparam int unsigned DEF_QUANTA_W  = 16;
    localparam int unsigned DEF_SLOT_BITS = 512;

    // Width needed to count positions 0..n-1 (at least 1).
    function automatic int unsigned cnt_width(input int unsigned n);
        return (n <= 2) ? 1 : $clog2(n);
    endfunction
endpackage

// File: rtl/pause_slot_prescaler.sv
// Module: pause_slot_prescaler
// Counts bit-time ticks and emits one strobe per SLOT_BITS ticks while run_i is high.
// Assumes: clear_i restarts the slot; when run_i is low the count is held at zero.
module pause_slot_prescaler #(
    parameter int unsigned SLOT_BITS = pause_pkg::DEF_SLOT_BITS
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clear_i,
    input  logic run_i,
    input  logic tick_i,
    output logic slot_o
);
    localparam int unsigned PW = pause_pkg::cnt_width(SLOT_BITS);
    localparam logic [PW-1:0] LAST = PW'(SLOT_BITS - 1);

    logic [PW-1:0] pos_q;

    // Purpose: flag the tick that completes a slot.
    always_comb begin
        slot_o = run_i && tick_i && !clear_i && (pos_q == LAST);
    end

    // Purpose: advance the slot position on each tick, wrapping at the slot end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q <= '0;
        end else if (clear_i || !run_i) begin
            pos_q <= '0;
        end else if (tick_i) begin
            pos_q <= (pos_q == LAST) ? '0 : pos_q + 1'b1;
        end
    end
endmodule

// File: rtl/pause_quanta_counter.sv
// Module: pause_quanta_counter
// Holds the remaining pause quanta, loads on request and steps down per slot.
// Assumes: a load takes priority over a step; a step at zero is ignored.
module pause_quanta_counter #(
    parameter int unsigned QUANTA_W = pause_pkg::DEF_QUANTA_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load_i,
    input  logic [QUANTA_W-1:0] value_i,
    input  logic                step_i,
    output logic [QUANTA_W-1:0] count_o,
    output logic                active_o
);
    logic [QUANTA_W-1:0] count_q;

    // Purpose: report a nonzero count as an active holdoff.
    always_comb begin
        count_o  = count_q;
        active_o = (count_q != '0);
    end

    // Purpose: load a new quanta value or step down once per slot.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            count_q <= '0;
        end else if (load_i) begin
            count_q <= value_i;
        end else if (step_i && (count_q != '0)) begin
            count_q <= count_q - 1'b1;
        end
    end
endmodule

// File: rtl/pause_grant_gate.sv
// Module: pause_grant_gate
// Combines the holdoff state with the transmitter busy flag into a start grant.
// Assumes: the scheduler starts a frame only while the grant is high.
module pause_grant_gate (
    input  logic holdoff_i,
    input  logic busy_i,
    output logic grant_o
);
    // Purpose: allow a new frame only when idle and not held off.
    always_comb begin
        grant_o = !holdoff_i && !busy_i;
    end
endmodule

// File: rtl/pause_holdoff.sv
// Module: pause_holdoff (top)
// Blocks the start of new frames for the quanta time of an accepted pause request.
// Assumes: pause_valid_i is a single-cycle strobe with a decoded value; bit_tick_i
// pulses once per bit time; requests count only in full-duplex operation.
module pause_holdoff #(
    parameter int unsigned QUANTA_W  = pause_pkg::DEF_QUANTA_W,
    parameter int unsigned SLOT_BITS = pause_pkg::DEF_SLOT_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                full_duplex_i,
    input  logic                pause_valid_i,
    input  logic [QUANTA_W-1:0] pause_quanta_i,
    input  logic                bit_tick_i,
    input  logic                tx_busy_i,
    output logic                tx_grant_o,
    output logic                paused_o
);
    logic                accept;
    logic                slot_done;
    logic                active;
    logic [QUANTA_W-1:0] count_q;

    // Purpose: accept a request only in full-duplex operation.
    always_comb begin
        accept = pause_valid_i && full_duplex_i;
    end

    pause_slot_prescaler #(
        .SLOT_BITS (SLOT_BITS)
    ) u_slot (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (accept),
        .run_i   (active),
        .tick_i  (bit_tick_i),
        .slot_o  (slot_done)
    );

    pause_quanta_counter #(
        .QUANTA_W (QUANTA_W)
    ) u_count (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (accept),
        .value_i  (pause_quanta_i),
        .step_i   (slot_done),
        .count_o  (count_q),
        .active_o (active)
    );

    pause_grant_gate u_gate (
        .holdoff_i (active),
        .busy_i    (tx_busy_i),
        .grant_o   (tx_grant_o)
    );

    // Purpose: expose the holdoff state.
    always_comb begin
        paused_o = active;
    end
endmodule

// File: rtl/pause_holdoff_chk.sv
// Module: pause_holdoff_chk
// Checker with temporal properties of the holdoff block, attached by bind.
module pause_holdoff_chk #(
    parameter int unsigned QUANTA_W = pause_pkg::DEF_QUANTA_W
) (
    input logic                clk,
    input logic                rst_n,
    input logic                full_duplex_i,
    input logic                pause_valid_i,
    input logic [QUANTA_W-1:0] pause_quanta_i,
    input logic                bit_tick_i,
    input logic                tx_busy_i,
    input logic                tx_grant_o,
    input logic                paused_o,
    input logic [QUANTA_W-1:0] count_q
);
    a_r1_no_grant_paused: assert property (@(posedge clk) disable iff (!rst_n)
        paused_o |-> !tx_grant_o);
    a_r1_no_grant_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_busy_i |-> !tx_grant_o);
    a_r2_load_pauses: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid_i && full_duplex_i && pause_quanta_i != '0) |=> paused_o);
    a_r4_reload_value: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid_i && full_duplex_i) |=> (count_q == $past(pause_quanta_i)));
    a_r5_zero_release: assert property (@(posedge clk) disable iff (!rst_n)
        (pause_valid_i && full_duplex_i && pause_quanta_i == '0) |=> !paused_o);
    a_r7_half_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (!full_duplex_i && !paused_o) |=> !paused_o);
    a_r9_no_tick_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bit_tick_i && !(pause_valid_i && full_duplex_i)) |=> $stable(count_q));
    a_r3_release_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(paused_o) && !$past(pause_valid_i && full_duplex_i)) |-> $past(bit_tick_i));
endmodule

bind pause_holdoff pause_holdoff_chk #(.QUANTA_W(QUANTA_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .full_duplex_i  (full_duplex_i),
    .pause_valid_i  (pause_valid_i),
    .pause_quanta_i (pause_quanta_i),
    .bit_tick_i     (bit_tick_i),
    .tx_busy_i      (tx_busy_i),
    .tx_grant_o     (tx_grant_o),
    .paused_o       (paused_o),
    .count_q        (count_q)
);

// File: tb/pause_holdoff_tb.sv
module pause_holdoff_tb;
    localparam int SLOT = 512;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        fd = 1'b1;
    logic        valid = 1'b0;
    logic [15:0] quanta = '0;
    logic        tick = 1'b0;
    logic        busy = 1'b0;
    logic        grant;
    logic        paused;

    int checks = 0;
    int fails  = 0;
    int exp_q     = 0;
    int exp_ticks = 0;

    always #2 clk = ~clk;

    pause_holdoff u_dut (
        .clk            (clk),
        .rst_n          (rst_n),
        .full_duplex_i  (fd),
        .pause_valid_i  (valid),
        .pause_quanta_i (quanta),
        .bit_tick_i     (tick),
        .tx_busy_i      (busy),
        .tx_grant_o     (grant),
        .paused_o       (paused)
    );

    function automatic bit exp_paused(input int q, input int t);
        return t < q * SLOT;
    endfunction

    function automatic bit exp_grant(input int q, input int t, input bit b);
        return !exp_paused(q, t) && !b;
    endfunction

    task automatic check(input string tag, input bit act, input bit exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
        end
    endtask

    // One cycle: apply inputs, update the reference at the edge, check at negedge.
    task automatic step(input bit v, input int q, input bit t, input bit b,
                        input bit f, input string tag);
        valid = v; quanta = 16'(q); tick = t; busy = b; fd = f;
        @(posedge clk);
        if (!rst_n) begin
            exp_q = 0; exp_ticks = 0;
        end else if (v && f) begin
            exp_q = q; exp_ticks = 0;
        end else if (t && exp_paused(exp_q, exp_ticks)) begin
            exp_ticks++;
        end
        @(negedge clk);
        check({tag, " paused"}, paused, exp_paused(exp_q, exp_ticks));
        check({tag, " grant"},  grant,  exp_grant(exp_q, exp_ticks, b));
    endtask

    task automatic run_ticks(input int n, input bit b, input string tag);
        for (int i = 0; i < n; i++) step(1'b0, 0, 1'b1, b, 1'b1, tag);
    endtask

    task automatic main_seq();
        @(negedge clk);
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, "R6 reset");
        rst_n = 1'b1;
        step(1'b0, 0, 1'b0, 1'b0, 1'b1, "R6 idle");
        step(1'b0, 0, 1'b0, 1'b1, 1'b1, "R1 busy idle");
        // Load Q=2, run to release with ticks every cycle.
        step(1'b1, 2, 1'b1, 1'b0, 1'b1, "R2 load");
        run_ticks(2 * SLOT + 3, 1'b0, "R3 countdown");
        // No ticks: no progress.
        step(1'b1, 1, 1'b0, 1'b0, 1'b1, "R2 load1");
        for (int i = 0; i < 700; i++) step(1'b0, 0, 1'b0, 1'b0, 1'b1, "R9 no tick");
        // Prescaler cleared on reload.
        run_ticks(300, 1'b1, "R8 partial");
        step(1'b1, 1, 1'b0, 1'b0, 1'b1, "R4 reload");
        run_ticks(300, 1'b0, "R8 after reload");
        check("R8 still paused", paused, 1'b1);
        // Reload with larger value.
        step(1'b1, 3, 1'b1, 1'b0, 1'b1, "R4 reload3");
        run_ticks(SLOT + 5, 1'b0, "R4 counting");
        // Zero quanta releases.
        step(1'b1, 0, 1'b1, 1'b1, 1'b1, "R5 zero");
        check("R5 released", paused, 1'b0);
        // Half-duplex ignores requests.
        step(1'b1, 5, 1'b1, 1'b0, 1'b0, "R7 half");
        check("R7 not paused", paused, 1'b0);
        step(1'b1, 1, 1'b1, 1'b0, 1'b1, "R2 load again");
        step(1'b1, 0, 1'b1, 1'b0, 1'b0, "R7 half zero");
        check("R7 holdoff kept", paused, 1'b1);
        run_ticks(SLOT + 2, 1'b0, "R3 release");
        // Constrained random.
        void'($urandom(32'd20240611));
        for (int i = 0; i < 40000; i++) begin
            bit v  = ($urandom_range(0, 199) == 0);
            int q  = $urandom_range(0, 3);
            bit t  = ($urandom_range(0, 1) == 1);
            bit b  = ($urandom_range(0, 3) == 0);
            bit f  = ($urandom_range(0, 7) != 0);
            step(v, q, t, b, f, "R3 random");
        end
    endtask

    initial begin
        fork
            main_seq();
            begin
                repeat (200000) @(posedge clk);
                checks++; fails++;
                $display("FAIL watchdog: actual=timeout expected=done");
            end
        join_any
        disable fork;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule